// File: doc/BRIEF.md
# Transport Stream Output Formatter

The block sits after the error-correcting stage of a cable receiver. It takes decoded transport packets one byte at a time. Each packet starts with a byte marked by `in_sop`, and its "could not be corrected" flag arrives with that first byte. The block presents every byte on two interfaces at once.

The first is a parallel byte bus with a data-enable strobe, a packet-sync pulse and an uncorrectable indicator. The second is a serial lane that sends each byte MSB first. The serial lane has its own gated bit clock and its own sync, enable and uncorrectable companion lines. The serial lane runs only while `ser_en` is high.

For a packet that could not be corrected, the block can mark the packet for downstream demultiplexers. It does this by setting the transport error indicator, which is the MSB of the byte that follows the sync byte. Two inhibit controls suppress this marking.

One serial bit lasts `2*BIT_HALF` clock cycles. The bit clock is low for the first half of the bit and high for the second half, so data changes on the falling edge and is stable on the rising edge. A full byte therefore takes `16*BIT_HALF` cycles. The source is expected to space bytes at least that far apart whenever the serial lane is in use.

Top module: `ts_out_formatter`

## Requirements
- R1: A byte accepted with `in_valid` high appears on `par_data` with `par_den` high in the next cycle. `par_den` is low in every cycle that does not follow an accepted byte, and `par_data` then holds its last value.
- R2: `par_sync` is high together with the output of a byte that was accepted with `in_sop` high. It is low for all other bytes and in idle cycles.
- R3: `par_uncor` takes the value of `in_uncor` when a start-of-packet byte is output. It keeps that value across every byte of the packet and the idle cycles between them, until the next start-of-packet byte.
- R4: The MSB (bit 7) of the byte output directly after a start-of-packet byte is forced to 1 when the packet is marked uncorrectable and both `rs_inhibit` and `ei_inhibit` are low. In every other case the bytes pass through unchanged.
- R5: Each byte accepted while `ser_en` is high is shifted out on `ser_data`, MSB first, as 8 bits of `2*BIT_HALF` cycles each, starting in the cycle after acceptance. `ser_clk` is low for the first `BIT_HALF` cycles of each bit and high for the rest, and `ser_data` never changes while `ser_clk` is high.
- R6: `ser_den` is high for exactly the 8 bit times of a byte being sent. `ser_clk` and `ser_data` stay low whenever `ser_den` is low.
- R7: `ser_sync` is high for all 8 bit times of a start-of-packet byte. `ser_uncor` is high for all bit times of every byte of an uncorrectable packet.
- R8: With `ser_en` low, all serial outputs go low at the next cycle and no byte is loaded. The parallel outputs are not affected, and both interfaces carry the same formatted bytes when both are active.
- R9: Bytes spaced exactly `16*BIT_HALF` cycles apart produce a continuous serial stream with no cycle of `ser_den` low between them. A byte that arrives earlier restarts the serial lane with the new byte.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid this cycle |
| in_data | input | 8 | Decoded packet byte |
| in_sop | input | 1 | Byte is the first (sync) byte of a packet |
| in_uncor | input | 1 | Packet uncorrectable, sampled with the start-of-packet byte |
| rs_inhibit | input | 1 | Suppresses error-indicator insertion |
| ei_inhibit | input | 1 | Suppresses error-indicator insertion |
| ser_en | input | 1 | Enables the serial lane |
| par_data | output | 8 | Parallel output byte |
| par_den | output | 1 | Parallel data valid |
| par_sync | output | 1 | Parallel packet-sync pulse |
| par_uncor | output | 1 | Parallel uncorrectable-packet indicator |
| ser_clk | output | 1 | Gated serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_den | output | 1 | Serial data enable |
| ser_sync | output | 1 | Serial sync-byte indicator |
| ser_uncor | output | 1 | Serial uncorrectable indicator |

## Verification
A stale packet-error flag in the block shows on `par_uncor` and `ser_uncor` at the first byte it touches. A missed or wrongly placed error-indicator insertion shows one cycle after the second byte of a packet is accepted. A phase or bit counter that has slipped shows on `ser_clk` or `ser_den` within one bit time, which is at most `2*BIT_HALF` cycles. The bench compares a behavioural model against every output on every clock, so each of these faults is reported in the first cycle it reaches a port.

// File: rtl/ts_out_formatter.sv
module ts_out_formatter #(
  parameter int BIT_HALF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_uncor,
  input  logic       rs_inhibit,
  input  logic       ei_inhibit,
  input  logic       ser_en,
  output logic [7:0] par_data,
  output logic       par_den,
  output logic       par_sync,
  output logic       par_uncor,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_den,
  output logic       ser_sync,
  output logic       ser_uncor
);
  localparam int BIT_CYC = 2 * BIT_HALF;
  localparam int PW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(BIT_CYC - 1);
  localparam logic [PW-1:0] PH_HI   = PW'(BIT_HALF);

  logic after_sop, pkt_bad;
  logic busy, s_sync, s_unc;
  logic [7:0] sh;
  logic [PW-1:0] ph;
  logic [2:0] bitn;

  wire bad_now  = in_sop ? in_uncor : pkt_bad;
  wire force_ei = !in_sop && after_sop && pkt_bad && !rs_inhibit && !ei_inhibit;
  wire [7:0] fmt = {in_data[7] | force_ei, in_data[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_data  <= '0;
      par_den   <= 1'b0;
      par_sync  <= 1'b0;
      par_uncor <= 1'b0;
      after_sop <= 1'b0;
      pkt_bad   <= 1'b0;
    end else begin
      par_den  <= in_valid;
      par_sync <= in_valid && in_sop;
      if (in_valid) begin
        par_data  <= fmt;
        after_sop <= in_sop;
        if (in_sop) begin
          pkt_bad   <= in_uncor;
          par_uncor <= in_uncor;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '0;
      ph     <= '0;
      bitn   <= '0;
      s_sync <= 1'b0;
      s_unc  <= 1'b0;
    end else if (!ser_en) begin
      busy <= 1'b0;
    end else if (in_valid) begin
      busy   <= 1'b1;
      sh     <= fmt;
      ph     <= '0;
      bitn   <= '0;
      s_sync <= in_sop;
      s_unc  <= bad_now;
    end else if (busy) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        sh <= {sh[6:0], 1'b0};
        if (bitn == 3'd7) busy <= 1'b0;
        else bitn <= bitn + 3'd1;
      end else begin
        ph <= ph + PW'(1);
      end
    end
  end

  assign ser_den   = busy;
  assign ser_clk   = busy && (ph >= PH_HI);
  assign ser_data  = busy && sh[7];
  assign ser_sync  = busy && s_sync;
  assign ser_uncor = busy && s_unc;

  p_den_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> par_den);
  p_den_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !par_den);
  p_sync_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    par_sync |-> par_den);
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));
  p_clk_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_den |-> (!ser_clk && !ser_data));
  p_ser_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sync |-> ser_den);
  p_ser_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> !ser_den);
endmodule

// File: tb/sim_ts_out_formatter.sv
module sim_ts_out_formatter;
  localparam int H = 1;
  localparam int BYTE_CYC = 16 * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_uncor = 0, rs_inhibit = 0, ei_inhibit = 0, ser_en = 0;
  logic [7:0] in_data = '0;
  logic [7:0] par_data;
  logic par_den, par_sync, par_uncor, ser_clk, ser_data, ser_den, ser_sync, ser_uncor;

  ts_out_formatter #(.BIT_HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
    .in_uncor(in_uncor), .rs_inhibit(rs_inhibit), .ei_inhibit(ei_inhibit), .ser_en(ser_en),
    .par_data(par_data), .par_den(par_den), .par_sync(par_sync), .par_uncor(par_uncor),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_den(ser_den), .ser_sync(ser_sync),
    .ser_uncor(ser_uncor));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0, win = 0;
  int gaps = 0;

  // behavioural reference
  logic [7:0] m_data;
  bit m_den, m_sync, m_unc, m_after, m_bad;
  bit s_act, s_sync, s_unc;
  logic [7:0] s_byte;
  int s_k;

  always @(posedge clk) begin
    logic [7:0] b;
    if (!rst_n) begin
      m_data = 0; m_den = 0; m_sync = 0; m_unc = 0; m_after = 0; m_bad = 0;
      s_act = 0; s_sync = 0; s_unc = 0; s_byte = 0; s_k = 0;
    end else begin
      b = in_data;
      if (in_valid && !in_sop && m_after && m_bad && !rs_inhibit && !ei_inhibit) b[7] = 1'b1;
      if (!ser_en) s_act = 0;
      else if (in_valid) begin
        s_act = 1; s_k = 0; s_byte = b; s_sync = in_sop;
        s_unc = in_sop ? in_uncor : m_bad;
      end else if (s_act) begin
        if (s_k == BYTE_CYC - 1) s_act = 0;
        else s_k++;
      end
      m_den = in_valid;
      m_sync = in_valid && in_sop;
      if (in_valid) begin
        m_data = b;
        m_after = in_sop;
        if (in_sop) begin m_bad = in_uncor; m_unc = in_uncor; end
      end
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      bit e_clk, e_dat;
      e_clk = s_act && ((s_k % (2*H)) >= H);
      e_dat = s_act && s_byte[7 - s_k/(2*H)];
      chk("R1", "par_den", par_den, m_den);
      chk("R4", "par_data", par_data, m_data);
      chk("R2", "par_sync", par_sync, m_sync);
      chk("R3", "par_uncor", par_uncor, m_unc);
      chk("R6", "ser_den", ser_den, s_act);
      chk("R5", "ser_clk", ser_clk, e_clk);
      chk("R5", "ser_data", ser_data, e_dat);
      chk("R7", "ser_sync", ser_sync, s_act && s_sync);
      chk("R7", "ser_uncor", ser_uncor, s_act && s_unc);
      if (win && !ser_den) gaps++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] d, input bit sop, input bit unc, input int gap);
    in_valid = 1; in_data = d; in_sop = sop; in_uncor = unc;
    tick();
    in_valid = 0; in_sop = 0; in_uncor = 0; in_data = 8'hA5;
    repeat (gap - 1) tick();
  endtask

  task automatic packet(input int len, input bit bad, input int gap, input int seed);
    send(8'h47, 1, bad, gap);
    send(8'h12 ^ seed[7:0] & 8'h7F, 0, 0, gap);
    for (int i = 2; i < len; i++) send(8'((i * 37 + seed) & 255), 0, 0, gap);
  endtask

  initial begin
    tick(); tick();
    @(negedge clk);
    // R10: reset state
    chk("R10", "par_den", par_den, 0);
    chk("R10", "par_data", par_data, 0);
    chk("R10", "par_sync", par_sync, 0);
    chk("R10", "par_uncor", par_uncor, 0);
    chk("R10", "ser_clk", ser_clk, 0);
    chk("R10", "ser_den", ser_den, 0);
    tick();
    rst_n = 1; cmp_on = 1; ser_en = 1;
    tick();
    // R9: back-to-back spacing gives a gap-free stream
    send(8'h47, 1, 0, BYTE_CYC);
    win = 1;
    for (int i = 1; i < 187; i++) send(8'(i * 11), 0, 0, BYTE_CYC);
    win = 0;
    send(8'h3C, 0, 0, BYTE_CYC);
    chk("R9", "serial_gap_cycles", gaps, 0);
    packet(188, 1, BYTE_CYC, 5);                       // R4 insertion active
    rs_inhibit = 1; packet(30, 1, BYTE_CYC, 9);        // R4 suppressed
    rs_inhibit = 0; ei_inhibit = 1; packet(30, 1, BYTE_CYC, 13);
    ei_inhibit = 0;
    ser_en = 0; packet(60, 1, 1, 21); packet(40, 0, 3, 2);   // R8 parallel only
    ser_en = 1; packet(40, 1, 5, 30);                  // R9 restarts
    packet(20, 0, 23, 7);
    send(8'h47, 1, 1, 6); ser_en = 0; tick(); tick(); ser_en = 1;   // R8 abort
    send(8'h80, 0, 0, BYTE_CYC + 4);
    packet(12, 1, 2, 3);
    repeat (40) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule